// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

Two independent first-in first-out buffers move 18-bit words in opposite directions between two ports, A and B. Each port has its own free-running clock and its own synchronous active-high reset. The two clocks may be unrelated or the same. The A-to-B buffer is loaded at port A and drained at port B. The B-to-A buffer is loaded at port B and drained at port A.

Each port has a single shared data bus that is either writing or reading. At each port, four controls decode into a write strobe, a read strobe and an output enable: an active-low select, a direction select (high means write), a write enable and a read enable. The data bus drivers are modelled as a data-out vector plus an output-enable bit.

The writing side of each buffer shows an input-ready flag. The reading side shows an output-ready flag. Reads use first-word-fall-through: when output-ready is high, the oldest unread word is already on the data output. Read and write positions cross between the clock domains as gray-coded pointers, each passed through two flip-flop stages.

Top module: `bidir_fifo_pair`

## Requirements
- R1: Words written at port A come out at port B in the same order, and words written at port B come out at port A in the same order, with all 18 bits intact.
- R2: A port's output enable is 1 only when its select is 0 and its direction select is 0. It is 0 for the other three combinations of those two inputs.
- R3: A word is stored on a rising clock edge only when select=0, direction=1, write enable=1 and that port's input-ready=1. A write attempted while input-ready=0 is discarded, and the buffer contents are left unchanged.
- R4: A word is consumed on a rising clock edge only when select=0, direction=0, read enable=1 and output-ready=1. A read attempted while output-ready=0 has no effect. Output-ready falls only after an accepted read.
- R5: With no reads, input-ready goes to 0 after exactly 2**ADDR_W+1 accepted writes (2**ADDR_W words in memory and one in the output register).
- R6: When a word enters an empty buffer, it appears on the reading port's data output in the same cycle that output-ready rises. While output-ready=1 and no read is made, the output word and the flag both hold.
- R7: After the last word is read, output-ready falls and the data output keeps that last word until output-ready rises again.
- R8: A cycle with both enables at 0 performs no buffer access, whatever the select and direction inputs do. Those inputs then affect only the output enable.
- R9: After reset, input-ready=1, output-ready=0 and the data output is all zeros.
- R10: Each gray-coded pointer changes by at most one bit per clock of its own domain, so the two-stage synchronizers never capture a multi-bit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| cs_a_n | input | 1 | Port A select, active low |
| wr_rd_a | input | 1 | Port A direction: 1 = write, 0 = read |
| wen_a | input | 1 | Port A write enable |
| ren_a | input | 1 | Port A read enable |
| din_a | input | DATA_W | Port A write data (into A-to-B buffer) |
| dout_a | output | DATA_W | Port A read data (from B-to-A buffer) |
| doe_a | output | 1 | Port A data output enable |
| ir_a | output | 1 | Input-ready of the A-to-B buffer |
| or_a | output | 1 | Output-ready of the B-to-A buffer |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| cs_b_n | input | 1 | Port B select, active low |
| wr_rd_b | input | 1 | Port B direction: 1 = write, 0 = read |
| wen_b | input | 1 | Port B write enable |
| ren_b | input | 1 | Port B read enable |
| din_b | input | DATA_W | Port B write data (into B-to-A buffer) |
| dout_b | output | DATA_W | Port B read data (from A-to-B buffer) |
| doe_b | output | 1 | Port B data output enable |
| ir_b | output | 1 | Input-ready of the B-to-A buffer |
| or_b | output | 1 | Output-ready of the A-to-B buffer |

## Verification
The assertions assume that both ports are reset together, by overlapping resets, before any traffic starts. A reset of only one side would leave the pointers of the two domains in disagreement. They also assume that the inputs are stable around the rising edge of their own clock. The bench asserts both resets together, holds them for several cycles of the slower clock, and changes every input only on the falling edge of that input's clock. It runs the two clocks at different periods so that the crossing is truly asynchronous. Each expectation is sampled only after several cycles of settling, so the checks do not depend on the exact synchronizer latency.

// File: rtl/bfp_pkg.sv
`timescale 1ns/1ps
package bfp_pkg;

  // Decoded per-port control
  typedef struct packed {
    logic wr;   // write strobe (before the ready qualifier)
    logic rd;   // read strobe (before the ready qualifier)
    logic oe;   // data bus drive enable
  } port_ctl_t;

  function automatic port_ctl_t decode_port(input logic sel_n, input logic dir_wr,
                                            input logic wen, input logic ren);
    port_ctl_t c;
    c.wr = !sel_n &&  dir_wr && wen;
    c.rd = !sel_n && !dir_wr && ren;
    c.oe = !sel_n && !dir_wr;
    return c;
  endfunction

  // Binary to reflected gray code (operands up to 16 bits)
  function automatic logic [15:0] bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/bfp_sync.sv
`timescale 1ns/1ps
module bfp_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/bfp_wr_ctl.sv
`timescale 1ns/1ps
module bfp_wr_ctl
  import bfp_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int PW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [PW-1:0]     rgray_s,
  output logic              wr_acc,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     wgray,
  output logic              ir
);
  logic [PW-1:0] wbin, wbin_nxt, wgray_nxt, full_pat;
  logic          full_nxt;

  assign wr_acc    = wr_req && ir;
  assign wbin_nxt  = wbin + PW'(wr_acc);
  assign wgray_nxt = PW'(bin2gray(16'(wbin_nxt)));
  // full: top two gray bits inverted, rest equal
  assign full_pat  = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
  assign full_nxt  = (wgray_nxt == full_pat);
  assign waddr     = wbin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      ir    <= 1'b1;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
      ir    <= !full_nxt;
    end
  end
endmodule

// File: rtl/bfp_rd_ctl.sv
`timescale 1ns/1ps
module bfp_rd_ctl
  import bfp_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int PW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [PW-1:0]     wgray_s,
  output logic              rd_acc,
  output logic              load,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rgray,
  output logic              valid
);
  logic [PW-1:0] rbin, rbin_nxt;
  logic          mem_has;

  assign mem_has  = (rgray != wgray_s);
  assign rd_acc   = rd_req && valid;
  assign load     = mem_has && (!valid || rd_acc);
  assign rbin_nxt = rbin + PW'(load);
  assign raddr    = rbin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      valid <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= PW'(bin2gray(16'(rbin_nxt)));
      if (load)        valid <= 1'b1;
      else if (rd_acc) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bfp_channel.sv
`timescale 1ns/1ps
module bfp_channel #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  output logic              ir,
  output logic [PW-1:0]     wgray,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rdata,
  output logic              ov,
  output logic [PW-1:0]     rgray
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray_s, rgray_s;
  logic              wr_acc, rd_acc, load;

  bfp_wr_ctl #(.ADDR_W(ADDR_W)) i_wr (
    .clk(wclk), .rst(wrst), .wr_req(wr_req), .rgray_s(rgray_s),
    .wr_acc(wr_acc), .waddr(waddr), .wgray(wgray), .ir(ir));

  bfp_rd_ctl #(.ADDR_W(ADDR_W)) i_rd (
    .clk(rclk), .rst(rrst), .rd_req(rd_req), .wgray_s(wgray_s),
    .rd_acc(rd_acc), .load(load), .raddr(raddr), .rgray(rgray), .valid(ov));

  bfp_sync #(.W(PW)) i_sync_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));
  bfp_sync #(.W(PW)) i_sync_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s));

  always_ff @(posedge wclk) begin
    if (wr_acc) mem[waddr] <= wdata;
  end

  // output register: keeps last word when the valid bit drops
  always_ff @(posedge rclk) begin
    if (rrst)      rdata <= '0;
    else if (load) rdata <= mem[raddr];
  end

  logic unused_rd_acc;
  assign unused_rd_acc = rd_acc;
endmodule

// File: rtl/bidir_fifo_pair.sv
`timescale 1ns/1ps
module bidir_fifo_pair
  import bfp_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              cs_a_n,
  input  logic              wr_rd_a,
  input  logic              wen_a,
  input  logic              ren_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  output logic              doe_a,
  output logic              ir_a,
  output logic              or_a,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              cs_b_n,
  input  logic              wr_rd_b,
  input  logic              wen_b,
  input  logic              ren_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              doe_b,
  output logic              ir_b,
  output logic              or_b
);
  port_ctl_t ctl_a, ctl_b;
  assign ctl_a = decode_port(cs_a_n, wr_rd_a, wen_a, ren_a);
  assign ctl_b = decode_port(cs_b_n, wr_rd_b, wen_b, ren_b);

  // named events for the checker
  logic          wr_strobe_a, rd_strobe_a, wr_strobe_b, rd_strobe_b;
  logic [PW-1:0] wgray_ab, rgray_ab, wgray_ba, rgray_ba;
  assign wr_strobe_a = ctl_a.wr;
  assign rd_strobe_a = ctl_a.rd;
  assign wr_strobe_b = ctl_b.wr;
  assign rd_strobe_b = ctl_b.rd;
  assign doe_a       = ctl_a.oe;
  assign doe_b       = ctl_b.oe;

  bfp_channel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ab (
    .wclk(clk_a), .wrst(rst_a), .wr_req(wr_strobe_a), .wdata(din_a),
    .ir(ir_a), .wgray(wgray_ab),
    .rclk(clk_b), .rrst(rst_b), .rd_req(rd_strobe_b),
    .rdata(dout_b), .ov(or_b), .rgray(rgray_ab));

  bfp_channel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ba (
    .wclk(clk_b), .wrst(rst_b), .wr_req(wr_strobe_b), .wdata(din_b),
    .ir(ir_b), .wgray(wgray_ba),
    .rclk(clk_a), .rrst(rst_a), .rd_req(rd_strobe_a),
    .rdata(dout_a), .ov(or_a), .rgray(rgray_ba));
endmodule

// File: rtl/bfp_checker.sv
`timescale 1ns/1ps
module bfp_checker #(
  parameter int DATA_W = 18,
  parameter int PW     = 10
) (
  input logic              clk_a,
  input logic              rst_a,
  input logic              clk_b,
  input logic              rst_b,
  input logic              ir_a,
  input logic              or_a,
  input logic              ir_b,
  input logic              or_b,
  input logic [DATA_W-1:0] dout_a,
  input logic [DATA_W-1:0] dout_b,
  input logic              rd_strobe_a,
  input logic              rd_strobe_b,
  input logic [PW-1:0]     wgray_ab,
  input logic [PW-1:0]     rgray_ab,
  input logic [PW-1:0]     wgray_ba,
  input logic [PW-1:0]     rgray_ba
);
  AST_BLOCK_WRITE_FULL_A: assert property (@(posedge clk_a) disable iff (rst_a) !ir_a |=> $stable(wgray_ab)); // R3
  AST_BLOCK_WRITE_FULL_B: assert property (@(posedge clk_b) disable iff (rst_b) !ir_b |=> $stable(wgray_ba)); // R3
  AST_OR_FALL_ON_READ_A: assert property (@(posedge clk_a) disable iff (rst_a) $fell(or_a) |-> $past(rd_strobe_a)); // R4
  AST_OR_FALL_ON_READ_B: assert property (@(posedge clk_b) disable iff (rst_b) $fell(or_b) |-> $past(rd_strobe_b)); // R4
  AST_HOLD_VALID_A: assert property (@(posedge clk_a) disable iff (rst_a) (or_a && !rd_strobe_a) |=> (or_a && $stable(dout_a))); // R6
  AST_HOLD_VALID_B: assert property (@(posedge clk_b) disable iff (rst_b) (or_b && !rd_strobe_b) |=> (or_b && $stable(dout_b))); // R6
  AST_KEEP_LAST_A: assert property (@(posedge clk_a) disable iff (rst_a) !or_a |=> (or_a || $stable(dout_a))); // R7
  AST_KEEP_LAST_B: assert property (@(posedge clk_b) disable iff (rst_b) !or_b |=> (or_b || $stable(dout_b))); // R7
  AST_RESET_FLAGS_A: assert property (@(posedge clk_a) disable iff (rst_a) $past(rst_a) |-> (ir_a && !or_a)); // R9
  AST_RESET_FLAGS_B: assert property (@(posedge clk_b) disable iff (rst_b) $past(rst_b) |-> (ir_b && !or_b)); // R9
  AST_GRAY_STEP_WAB: assert property (@(posedge clk_a) disable iff (rst_a) $countones(wgray_ab ^ $past(wgray_ab)) <= 1); // R10
  AST_GRAY_STEP_RAB: assert property (@(posedge clk_b) disable iff (rst_b) $countones(rgray_ab ^ $past(rgray_ab)) <= 1); // R10
  AST_GRAY_STEP_WBA: assert property (@(posedge clk_b) disable iff (rst_b) $countones(wgray_ba ^ $past(wgray_ba)) <= 1); // R10
  AST_GRAY_STEP_RBA: assert property (@(posedge clk_a) disable iff (rst_a) $countones(rgray_ba ^ $past(rgray_ba)) <= 1); // R10
endmodule

bind bidir_fifo_pair bfp_checker #(.DATA_W(DATA_W), .PW(ADDR_W + 1)) i_bfp_checker (
  .clk_a(clk_a), .rst_a(rst_a), .clk_b(clk_b), .rst_b(rst_b),
  .ir_a(ir_a), .or_a(or_a), .ir_b(ir_b), .or_b(or_b),
  .dout_a(dout_a), .dout_b(dout_b),
  .rd_strobe_a(rd_strobe_a), .rd_strobe_b(rd_strobe_b),
  .wgray_ab(wgray_ab), .rgray_ab(rgray_ab), .wgray_ba(wgray_ba), .rgray_ba(rgray_ba));

// File: tb/test_bidir_fifo_pair.sv
`timescale 1ns/1ps
module test_bidir_fifo_pair;
  localparam int DW  = 18;
  localparam int AW  = 4;
  localparam int CAP = (1 << AW) + 1;

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic cs_a_n = 1, wr_rd_a = 0, wen_a = 0, ren_a = 0;
  logic cs_b_n = 1, wr_rd_b = 0, wen_b = 0, ren_b = 0;
  logic [DW-1:0] din_a = '0, din_b = '0, dout_a, dout_b;
  logic doe_a, doe_b, ir_a, ir_b, or_a, or_b;
  int checks = 0, fails = 0;

  always #2 clk_a = ~clk_a;   // 250 MHz
  always #3 clk_b = ~clk_b;   // unrelated second clock

  bidir_fifo_pair #(.DATA_W(DW), .ADDR_W(AW)) i_bidir_fifo_pair (.*);

  // {sel_n, dir, word}
  localparam logic [DW+1:0] VEC [8] = '{
    {1'b0, 1'b0, 18'h00001}, {1'b0, 1'b1, 18'h3FFFF},
    {1'b1, 1'b0, 18'h2AAAA}, {1'b1, 1'b1, 18'h15555},
    {1'b1, 1'b1, 18'h00000}, {1'b0, 1'b0, 18'h20001},
    {1'b0, 1'b1, 18'h0F0F0}, {1'b1, 1'b0, 18'h30C3C}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge clk_a);
  endtask
  task automatic wait_b(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  task automatic write_a(input logic [DW-1:0] w);
    @(negedge clk_a); cs_a_n = 0; wr_rd_a = 1; wen_a = 1; din_a = w;
    @(negedge clk_a); wen_a = 0;
  endtask
  task automatic write_b(input logic [DW-1:0] w);
    @(negedge clk_b); cs_b_n = 0; wr_rd_b = 1; wen_b = 1; din_b = w;
    @(negedge clk_b); wen_b = 0;
  endtask

  // R1 / R6: the word must be present before the read strobe
  task automatic read_b(input logic [DW-1:0] exp, input string tag);
    @(negedge clk_b); cs_b_n = 0; wr_rd_b = 0;
    for (int k = 0; k < 40 && !or_b; k++) @(negedge clk_b);
    chk(tag, {14'd0, dout_b}, {14'd0, exp});
    ren_b = 1;
    @(negedge clk_b); ren_b = 0;
  endtask
  task automatic read_a(input logic [DW-1:0] exp, input string tag);
    @(negedge clk_a); cs_a_n = 0; wr_rd_a = 0;
    for (int k = 0; k < 40 && !or_a; k++) @(negedge clk_a);
    chk(tag, {14'd0, dout_a}, {14'd0, exp});
    ren_a = 1;
    @(negedge clk_a); ren_a = 0;
  endtask

  task automatic do_reset();
    rst_a = 1; rst_b = 1;
    wait_b(6);
    @(negedge clk_a); rst_a = 0;
    @(negedge clk_b); rst_b = 0;
    wait_b(2);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int acc;
    do_reset();
    // R9 reset state
    chk("R9 ir_a", {31'd0, ir_a}, 1);
    chk("R9 ir_b", {31'd0, ir_b}, 1);
    chk("R9 or_a", {31'd0, or_a}, 0);
    chk("R9 or_b", {31'd0, or_b}, 0);
    chk("R9 dout_b", {14'd0, dout_b}, 0);
    chk("R2 doe_a idle", {31'd0, doe_a}, 0);

    // Table: R2 / R8 decode with enables low, then load the word at A
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a); cs_a_n = VEC[i][DW+1]; wr_rd_a = VEC[i][DW];
      @(negedge clk_b); cs_b_n = VEC[i][DW+1]; wr_rd_b = VEC[i][DW];
      @(negedge clk_a);
      chk("R2 doe_a", {31'd0, doe_a}, {31'd0, !VEC[i][DW+1] && !VEC[i][DW]});
      chk("R2 doe_b", {31'd0, doe_b}, {31'd0, !VEC[i][DW+1] && !VEC[i][DW]});
      write_a(VEC[i][DW-1:0]);
    end
    wait_b(8);
    // R6: first word already presented with output-ready high
    chk("R6 or_b high", {31'd0, or_b}, 1);
    chk("R6 first word", {14'd0, dout_b}, {14'd0, VEC[0][DW-1:0]});
    // R1 / R8: all words, in order, none lost to idle decode changes
    for (int i = 0; i < 8; i++) read_b(VEC[i][DW-1:0], "R1 A->B order");
    wait_b(3);
    // R7
    chk("R7 or_b low", {31'd0, or_b}, 0);
    chk("R7 last word kept", {14'd0, dout_b}, {14'd0, VEC[7][DW-1:0]});

    // R1 reverse direction
    write_b(18'h1234A); write_b(18'h2ABCD); write_b(18'h3FFFE);
    @(negedge clk_b); cs_b_n = 1;
    wait_a(10);
    chk("R6 or_a high", {31'd0, or_a}, 1);
    read_a(18'h1234A, "R1 B->A w0");
    read_a(18'h2ABCD, "R1 B->A w1");
    read_a(18'h3FFFE, "R1 B->A w2");

    // R4: reads with output-ready low are ignored
    @(negedge clk_b); cs_b_n = 0; wr_rd_b = 0; ren_b = 1;
    wait_b(5);
    ren_b = 0;
    write_a(18'h0BEEF);
    read_b(18'h0BEEF, "R4 no effect of empty reads");
    wait_b(3);

    // R5 / R3: fill without reading, extra writes dropped
    acc = 0;
    @(negedge clk_b); cs_b_n = 1;
    @(negedge clk_a); cs_a_n = 0; wr_rd_a = 1;
    for (int c = 0; c < 60; c++) begin
      if (ir_a) begin din_a = 18'h100 + 18'(acc); wen_a = 1; acc++; end
      else wen_a = 1;
      @(negedge clk_a);
    end
    wen_a = 0;
    chk("R5 accepted writes", acc, CAP);
    chk("R5 ir_a low when full", {31'd0, ir_a}, 0);
    for (int i = 0; i < CAP; i++) read_b(18'h100 + 18'(i), "R3 full drain order");
    wait_b(4);
    chk("R3 no extra word", {31'd0, or_b}, 0);
    wait_a(6);
    chk("R5 ir_a back high", {31'd0, ir_a}, 1);

    // R9 reset with data in flight
    write_a(18'h3A5A5); write_a(18'h05A5A);
    wait_b(6);
    do_reset();
    chk("R9 or_b after reset", {31'd0, or_b}, 0);
    chk("R9 dout_b after reset", {14'd0, dout_b}, 0);
    chk("R9 ir_a after reset", {31'd0, ir_a}, 1);
    write_a(18'h11111);
    read_b(18'h11111, "R9 clean after reset");

    summary();
  end
endmodule